// File: doc/BRIEF.md
# Shift, Rotate and Nibble-Swap Unit

This block takes one byte-wide operand, the current carry flag and a three-bit operation code, and produces the shifted, rotated or nibble-swapped result together with new zero, carry, negative, overflow and signed-test flag values. It supports logical shifts in both directions, rotates in both directions through the carry flag, an arithmetic right shift that keeps the sign bit, and a swap of the two halves of the operand. The unit is one pipeline stage. An operation presented with `in_valid` high is captured on a rising clock edge, and its result appears on the outputs directly after that edge. It can accept a new operation on every cycle.

Each flag has its own write-enable output. A status register outside this block stores a flag only when that flag's enable is high, so any flag an operation does not affect keeps its old value. The nibble swap and the two unused operation codes write no flag at all. The half-carry and transfer-bit flags are never written by this unit, so it has no outputs for them.

The `WIDTH` parameter sets the operand width. It must be even and at least 2. The swap operation exchanges the two halves of the operand.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 (logical shift left) gives result bit n+1 equal to operand bit n, gives result bit 0 equal to 0, and gives carry equal to operand bit WIDTH-1.
- R2: Operation code 1 (logical shift right) gives result bit n equal to operand bit n+1, gives result bit WIDTH-1 equal to 0, and gives carry equal to operand bit 0.
- R3: Operation code 2 (rotate left through carry) gives result bit 0 equal to the incoming carry, gives result bit n+1 equal to operand bit n, and gives carry equal to operand bit WIDTH-1.
- R4: Operation code 3 (rotate right through carry) gives result bit WIDTH-1 equal to the incoming carry, gives result bit n equal to operand bit n+1, and gives carry equal to operand bit 0.
- R5: Operation code 4 (arithmetic shift right) gives result bit n equal to operand bit n+1, keeps result bit WIDTH-1 equal to operand bit WIDTH-1, and gives carry equal to operand bit 0.
- R6: Operation code 5 (swap) exchanges the upper half and the lower half of the operand. All five flag write-enables are 0, and all five flag value outputs read 0.
- R7: For operation codes 0 to 4, Z is 1 exactly when the result is all zeros, and N equals the top bit of the result.
- R8: For operation codes 0 to 4, V equals N XOR C and S equals N XOR V. All five write-enables (Z, C, N, V, S) are 1.
- R9: Operation codes 6 and 7 pass the operand through unchanged. All five write-enables are 0, and all five flag value outputs read 0.
- R10: `out_valid` is 1 in the cycle after each cycle in which `in_valid` was 1 at the clock edge, and is 0 otherwise. While `out_valid` is 0, every write-enable is 0.
- R11: While `rst_n` is low, `out_valid`, `out_result` and every flag and write-enable output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 3 | Operation code (0 to 7) |
| in_operand | input | WIDTH | Operand |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result and flags are valid |
| out_result | output | WIDTH | Result |
| out_z | output | 1 | New zero flag |
| out_c | output | 1 | New carry flag |
| out_n | output | 1 | New negative flag |
| out_v | output | 1 | New overflow flag |
| out_s | output | 1 | New signed-test flag |
| out_we_z | output | 1 | Write-enable for Z |
| out_we_c | output | 1 | Write-enable for C |
| out_we_n | output | 1 | Write-enable for N |
| out_we_v | output | 1 | Write-enable for V |
| out_we_s | output | 1 | Write-enable for S |

## Verification
The bench builds the unit with the default `WIDTH` of 8. At that width every operand value, both carry values and all eight operation codes can be swept in a few thousand cycles. The sweep covers the corner cases directly: a zero result, the sign bit kept by the arithmetic shift, the carry-in reaching bit 0 or the top bit, and the unused codes. Idle cycles are placed between operations so that the bench sees the enables fall back to 0 whenever no result is valid.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_RCL  = 3'd2,
        OP_RCR  = 3'd3,
        OP_SAR  = 3'd4,
        OP_SWAP = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } shrot_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
        logic s;
    } shrot_flags_t;

endpackage

// File: rtl/shrot_datapath.sv
module shrot_datapath
    import shrot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  shrot_op_e          op,
    input  logic [WIDTH-1:0]   operand,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   result,
    output logic               carry_out,
    output logic               touches_flags
);
    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;

    logic [WIDTH-1:0] swapped;

    // Build the half-exchange bit by bit.
    for (genvar i = 0; i < HALF; i++) begin : g_swap
        assign swapped[i]        = operand[i + HALF];
        assign swapped[i + HALF] = operand[i];
    end

    always_comb begin
        result        = operand;
        carry_out     = 1'b0;
        touches_flags = 1'b0;
        unique case (op)
            OP_SHL: begin
                result        = {operand[MSB-1:0], 1'b0};
                carry_out     = operand[MSB];
                touches_flags = 1'b1;
            end
            OP_SHR: begin
                result        = {1'b0, operand[MSB:1]};
                carry_out     = operand[0];
                touches_flags = 1'b1;
            end
            OP_RCL: begin
                result        = {operand[MSB-1:0], carry_in};
                carry_out     = operand[MSB];
                touches_flags = 1'b1;
            end
            OP_RCR: begin
                result        = {carry_in, operand[MSB:1]};
                carry_out     = operand[0];
                touches_flags = 1'b1;
            end
            OP_SAR: begin
                result        = {operand[MSB], operand[MSB:1]};
                carry_out     = operand[0];
                touches_flags = 1'b1;
            end
            OP_SWAP: begin
                result        = swapped;
            end
            OP_RSV6, OP_RSV7: begin
                result        = operand;
            end
        endcase
    end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] result,
    input  logic             carry_out,
    input  logic             touches_flags,
    output shrot_flags_t     value,
    output shrot_flags_t     wr_en
);
    logic neg, ovf;

    assign neg = result[WIDTH-1];
    assign ovf = neg ^ carry_out;

    always_comb begin
        value = '0;
        wr_en = '0;
        if (touches_flags) begin
            value.z = (result == '0);
            value.c = carry_out;
            value.n = neg;
            value.v = ovf;
            value.s = neg ^ ovf;
            wr_en   = '1;
        end
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [WIDTH-1:0] in_operand,
    input  logic             in_carry,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_result,
    output logic             out_z,
    output logic             out_c,
    output logic             out_n,
    output logic             out_v,
    output logic             out_s,
    output logic             out_we_z,
    output logic             out_we_c,
    output logic             out_we_n,
    output logic             out_we_v,
    output logic             out_we_s
);
    logic [WIDTH-1:0] dp_result;
    logic             dp_carry;
    logic             dp_touch;
    shrot_flags_t     fl_value, fl_wren;

    logic             valid_q;
    logic [WIDTH-1:0] result_q;
    shrot_flags_t     value_q, wren_q;

    shrot_datapath #(.WIDTH(WIDTH)) datapath_i (
        .op            (shrot_op_e'(in_op)),
        .operand       (in_operand),
        .carry_in      (in_carry),
        .result        (dp_result),
        .carry_out     (dp_carry),
        .touches_flags (dp_touch)
    );

    shrot_flags #(.WIDTH(WIDTH)) flags_i (
        .result        (dp_result),
        .carry_out     (dp_carry),
        .touches_flags (dp_touch),
        .value         (fl_value),
        .wr_en         (fl_wren)
    );

    // Output stage register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            result_q <= '0;
            value_q  <= '0;
            wren_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                result_q <= dp_result;
                value_q  <= fl_value;
                wren_q   <= fl_wren;
            end else begin
                wren_q   <= '0;
            end
        end
    end

    always_comb begin
        out_valid  = valid_q;
        out_result = result_q;
        out_z      = value_q.z;
        out_c      = value_q.c;
        out_n      = value_q.n;
        out_v      = value_q.v;
        out_s      = value_q.s;
        out_we_z   = wren_q.z;
        out_we_c   = wren_q.c;
        out_we_n   = wren_q.n;
        out_we_v   = wren_q.v;
        out_we_s   = wren_q.s;
    end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_op,
    input logic [WIDTH-1:0] in_operand,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_result,
    input logic             out_z,
    input logic             out_c,
    input logic             out_n,
    input logic             out_v,
    input logic             out_s,
    input logic             out_we_z,
    input logic             out_we_c,
    input logic             out_we_n,
    input logic             out_we_v,
    input logic             out_we_s
);
    logic armed;
    logic any_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign any_we = out_we_z | out_we_c | out_we_n | out_we_v | out_we_s;

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !any_we);

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_we_z |-> (out_z == (out_result == '0)));

    p_neg_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_we_n |-> (out_n == out_result[WIDTH-1]));

    p_ovf_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_we_v |-> ((out_v == (out_n ^ out_c)) && (out_s == (out_n ^ out_v))));

    p_swap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && $past(in_op) == 3'd5) |-> !any_we);

    p_sar_keeps_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && $past(in_op) == 3'd4)
            |-> (out_result[WIDTH-1] == $past(in_operand[WIDTH-1])));

    p_reserved_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && $past(in_op) >= 3'd6)
            |-> (out_result == $past(in_operand) && !any_we));
endmodule

bind shrot_unit shrot_unit_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_z      (out_z),
    .out_c      (out_c),
    .out_n      (out_n),
    .out_v      (out_v),
    .out_s      (out_s),
    .out_we_z   (out_we_z),
    .out_we_c   (out_we_c),
    .out_we_n   (out_we_n),
    .out_we_v   (out_we_v),
    .out_we_s   (out_we_s)
);

// File: tb/shrot_unit_tb_top.sv
`timescale 1ns/1ps
module shrot_unit_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   in_op = '0;
    logic [W-1:0] in_operand = '0;
    logic         in_carry = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_result;
    logic out_z, out_c, out_n, out_v, out_s;
    logic out_we_z, out_we_c, out_we_n, out_we_v, out_we_s;

    int checks = 0;
    int errors = 0;
    bit monitor_on = 1'b0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [2:0]   op;
        logic [W-1:0] res;
        logic [4:0]   val;
        logic [4:0]   we;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    shrot_unit #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_operand(in_operand), .in_carry(in_carry),
        .out_valid(out_valid), .out_result(out_result),
        .out_z(out_z), .out_c(out_c), .out_n(out_n), .out_v(out_v), .out_s(out_s),
        .out_we_z(out_we_z), .out_we_c(out_we_c), .out_we_n(out_we_n),
        .out_we_v(out_we_v), .out_we_s(out_we_s)
    );

    function automatic exp_t model(input logic [2:0] op, input logic [W-1:0] a, input logic ci);
        exp_t e;
        logic c, z, n, v;
        e.op = op;
        c = 1'b0;
        case (op)
            3'd0: begin e.res = {a[W-2:0], 1'b0}; c = a[W-1]; end   // R1
            3'd1: begin e.res = {1'b0, a[W-1:1]}; c = a[0];   end   // R2
            3'd2: begin e.res = {a[W-2:0], ci};   c = a[W-1]; end   // R3
            3'd3: begin e.res = {ci, a[W-1:1]};   c = a[0];   end   // R4
            3'd4: begin e.res = {a[W-1], a[W-1:1]}; c = a[0]; end   // R5
            3'd5: e.res = {a[W/2-1:0], a[W-1:W/2]};                 // R6
            default: e.res = a;                                     // R9
        endcase
        if (op <= 3'd4) begin
            z = (e.res == '0);
            n = e.res[W-1];
            v = n ^ c;
            e.val = {z, c, n, v, n ^ v};                            // R7 R8
            e.we  = 5'b11111;
        end else begin
            e.val = '0;
            e.we  = '0;
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1 R7 R8";
            3'd1: return "R2 R7 R8";
            3'd2: return "R3 R7 R8";
            3'd3: return "R4 R7 R8";
            3'd4: return "R5 R7 R8";
            3'd5: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic drive(input logic [2:0] op, input logic [W-1:0] a, input logic ci);
        @(negedge clk);
        in_valid   = 1'b1;
        in_op      = op;
        in_operand = a;
        in_carry   = ci;
        exp_q.push_back(model(op, a, ci));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            in_operand = ~in_operand;
            in_carry   = ~in_carry;
        end
    endtask

    // Monitor: samples 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (monitor_on) begin
                logic [4:0] we_now, val_now;
                we_now  = {out_we_z, out_we_c, out_we_n, out_we_v, out_we_s};
                val_now = {out_z, out_c, out_n, out_v, out_s};
                checks++;
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R10: out_valid=1 with no pending operation (expected 0)");
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        if (out_result !== e.res || val_now !== e.val || we_now !== e.we) begin
                            errors++;
                            $display("FAIL %s: op=%0d result=%h flags=%b we=%b expected result=%h flags=%b we=%b",
                                     tag_of(e.op), e.op, out_result, val_now, we_now, e.res, e.val, e.we);
                        end
                    end
                end else begin
                    if (we_now !== 5'b0 || exp_q.size() != 0) begin
                        errors++;
                        $display("FAIL R10: idle cycle we=%b pending=%0d expected we=00000 pending=0",
                                 we_now, exp_q.size());
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        for (int cyc = 0; cyc < 20000; cyc++) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete (expected completion)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (out_valid !== 1'b0 || out_result !== '0 ||
            {out_z, out_c, out_n, out_v, out_s, out_we_z, out_we_c, out_we_n, out_we_v, out_we_s} !== '0) begin
            errors++;
            $display("FAIL R11: reset outputs valid=%b result=%h expected all zero", out_valid, out_result);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        monitor_on = 1'b1;

        // Directed corners
        drive(3'd0, 8'h80, 1'b0);   // R1: zero result, carry out
        drive(3'd1, 8'h01, 1'b1);   // R2: zero result
        drive(3'd2, 8'h00, 1'b1);   // R3: carry into bit 0
        drive(3'd3, 8'h00, 1'b1);   // R4: carry into top bit
        drive(3'd4, 8'h81, 1'b0);   // R5: sign kept
        drive(3'd5, 8'hA5, 1'b1);   // R6
        drive(3'd6, 8'h3C, 1'b1);   // R9
        drive(3'd7, 8'hC3, 1'b0);   // R9
        idle(2);                    // R10

        // Exhaustive sweep with periodic gaps
        n = 0;
        for (int op = 0; op < 8; op++)
            for (int ci = 0; ci < 2; ci++)
                for (int a = 0; a < 256; a++) begin
                    drive(op[2:0], a[W-1:0], ci[0]);
                    n++;
                    if (n % 37 == 0) idle(1);
                end
        idle(4);
        monitor_on = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule